// File: doc/BRIEF.md
# Synchronous Bit-Bang Sample-Then-Drive Engine

This block turns a stream of host bytes into pin activity on a parallel I/O bus, one byte per transaction. Each transaction first captures the present state of the bus into a read-back queue, then one system clock later loads the new byte into the output register. Because the capture always comes before the drive, the read-back stream runs one byte behind the written stream. To read the pins that the last written byte produced, the host writes one more byte, for example a copy of the last one.

Transactions are paced by an internal divided tick, with at most one per tick. A transaction is allowed only while the read-back queue has a free entry for the sample it will produce, so a host that stops reading stalls the writer. A per-pin direction mask selects which pins the engine drives. A mode byte enables the engine with the value 0x04, and clears it back to its reset state with the value 0x00.

Top module: `sbb_engine`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge that samples `mode_i == 8'h00`, `pins_o` becomes all ones (0xFF at the default width) and the read-back queue is emptied (`rd_valid_o` low).
- R2: `wr_ready_o` is high only while `mode_i == 8'h04`. Under any other mode value no byte is accepted, and the pins and the queue are not changed by `wr_valid_i`.
- R3: `wr_ready_o` is low while the read-back queue holds DEPTH entries (4 by default), so the queue never overflows.
- R4: A byte is accepted on a clock edge where `wr_valid_i` and `wr_ready_o` are both high. On that edge the bus sample is pushed to the queue and `pins_o` keeps its old value. On the next edge `pins_o` takes the accepted byte.
- R5: The sample holds, for each bit with `dir_i` = 1, the value `pins_o` is driving, and for each bit with `dir_i` = 0, the value on `pins_i`.
- R6: Read-back lags the writes by one byte. Starting from 0xFF with all pins outputs, writing 0x55, 0xAA returns 0xFF, 0x55, and writing 0x55, 0xAA, 0xAA returns 0xFF, 0x55, 0xAA.
- R7: The queue returns samples in acceptance order. `rd_valid_o` is high while it is non-empty, an entry is removed on an edge with `rd_valid_o` and `rd_ready_i` both high, and a stalled head entry stays stable.
- R8: Acceptances are at least TICK_DIV clocks apart (4 by default), and two acceptances are never on consecutive edges.
- R9: With no acceptance pending and no clear, `pins_o` holds its last value.
- R10: `pins_oe_o` equals `dir_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 8 | Mode byte: 0x04 runs the engine, 0x00 clears it |
| dir_i | input | W | Per-pin direction, 1 = driven by the engine |
| wr_valid_i | input | 1 | Host byte available |
| wr_data_i | input | W | Host byte to drive |
| wr_ready_o | output | 1 | Engine accepts a byte on this edge |
| rd_valid_o | output | 1 | Read-back sample available |
| rd_data_o | output | W | Oldest read-back sample |
| rd_ready_i | input | 1 | Host takes the read-back sample |
| pins_i | input | W | Bus value seen at the pins |
| pins_o | output | W | Output register driven to the pins |
| pins_oe_o | output | W | Per-pin output enable |

## Verification
The assertions check on every cycle that ready is withheld outside the run mode and while the queue is full, that the pins move exactly one edge after an acceptance and hold otherwise, that a clear forces the pins high and empties the queue, and that a stalled read-back head does not change. Only the bench scenarios can show the data relation between writes and read-back: the one-byte lag on the example sequences, the per-bit mix of driven and external values across a sweep of direction masks, the first-in first-out order after a full queue, and the exact tick spacing between acceptances.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

   typedef enum logic [7:0] {
      SBB_MODE_CLEAR = 8'h00,
      SBB_MODE_SYNC  = 8'h04
   } sbb_mode_e;

   typedef struct packed {
      logic run;
      logic clear;
   } sbb_ctl_t;

   function automatic sbb_ctl_t sbb_decode(input logic [7:0] mode);
      sbb_ctl_t c;
      c.run   = (mode == SBB_MODE_SYNC);
      c.clear = (mode == SBB_MODE_CLEAR);
      return c;
   endfunction

endpackage

// File: rtl/sbb_tick_gen.sv
module sbb_tick_gen #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   initial begin
      if (DIV < 1) $fatal(1, "sbb_tick_gen: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_every
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/sbb_rb_fifo.sv
module sbb_rb_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);

   localparam logic [CW-1:0] CAP = CW'(DEPTH);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "sbb_rb_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CAP);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (clear) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sbb_pin_stage.sv
module sbb_pin_stage #(
   parameter int unsigned   W         = 8,
   parameter logic [W-1:0]  RESET_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         start,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] pins_in,
   output logic [W-1:0] drive,
   output logic [W-1:0] sample,
   output logic         busy
);

   logic [W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive <= RESET_VAL;
         hold  <= '0;
         busy  <= 1'b0;
      end else if (clear) begin
         drive <= RESET_VAL;
         hold  <= '0;
         busy  <= 1'b0;
      end else if (start) begin
         hold  <= wr_data;
         busy  <= 1'b1;
      end else if (busy) begin
         drive <= hold;
         busy  <= 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sample[i] = dir[i] ? drive[i] : pins_in[i];
      end
   endgenerate

endmodule

// File: rtl/sbb_engine.sv
module sbb_engine #(
   parameter int unsigned  W         = 8,
   parameter int unsigned  DEPTH     = 4,
   parameter int unsigned  TICK_DIV  = 4,
   parameter logic [W-1:0] RESET_VAL = '1,
   localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [7:0]   mode_i,
   input  logic [W-1:0] dir_i,
   input  logic         wr_valid_i,
   input  logic [W-1:0] wr_data_i,
   output logic         wr_ready_o,
   output logic         rd_valid_o,
   output logic [W-1:0] rd_data_o,
   input  logic         rd_ready_i,
   input  logic [W-1:0] pins_i,
   output logic [W-1:0] pins_o,
   output logic [W-1:0] pins_oe_o
);
   import sbb_pkg::*;

   initial begin
      if (W < 1) $fatal(1, "sbb_engine: W must be at least 1");
   end

   sbb_ctl_t     ctl;
   logic         tick;
   logic         accept;
   logic         pop;
   logic         fifo_empty, fifo_full;
   logic [CW-1:0] fifo_cnt;
   logic         stage_busy;
   logic [W-1:0] sample;

   assign ctl        = sbb_decode(mode_i);
   assign wr_ready_o = ctl.run & tick & ~fifo_full & ~stage_busy;
   assign accept     = wr_valid_i & wr_ready_o;
   assign rd_valid_o = ~fifo_empty;
   assign pop        = rd_valid_o & rd_ready_i;
   assign pins_oe_o  = dir_i;

   sbb_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   sbb_pin_stage #(.W(W), .RESET_VAL(RESET_VAL)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ctl.clear),
      .start   (accept),
      .wr_data (wr_data_i),
      .dir     (dir_i),
      .pins_in (pins_i),
      .drive   (pins_o),
      .sample  (sample),
      .busy    (stage_busy)
   );

   sbb_rb_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (ctl.clear),
      .push      (accept),
      .push_data (sample),
      .pop       (pop),
      .head      (rd_data_o),
      .count     (fifo_cnt),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

endmodule

// File: rtl/sbb_engine_chk.sv
module sbb_engine_chk #(
   parameter int unsigned  W         = 8,
   parameter int unsigned  DEPTH     = 4,
   parameter logic [W-1:0] RESET_VAL = '1,
   localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    mode_i,
   input logic          wr_valid_i,
   input logic [W-1:0]  wr_data_i,
   input logic          wr_ready_o,
   input logic          rd_valid_o,
   input logic          rd_ready_i,
   input logic [W-1:0]  rd_data_o,
   input logic [W-1:0]  pins_o,
   input logic [CW-1:0] fifo_cnt,
   input logic          stage_busy
);

   localparam logic [CW-1:0] CAP = CW'(DEPTH);

   logic acc;
   assign acc = wr_valid_i & wr_ready_o;

   // R1
   clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 8'h00) |=> (pins_o == RESET_VAL && !rd_valid_o));

   // R2
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 8'h04) |-> !wr_ready_o);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready_o |-> (fifo_cnt < CAP));

   // R4
   drive_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (pins_o == $past(pins_o)));

   // R4
   drive_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc ##1 (mode_i != 8'h00) |=> (pins_o == $past(wr_data_i, 2)));

   // R8
   one_per_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !(wr_valid_i && wr_ready_o));

   // R7
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_ready_i && mode_i != 8'h00) |=> (rd_valid_o && $stable(rd_data_o)));

   // R9
   pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !stage_busy && mode_i != 8'h00) |=> $stable(pins_o));

endmodule

bind sbb_engine sbb_engine_chk #(.W(W), .DEPTH(DEPTH), .RESET_VAL(RESET_VAL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .wr_valid_i (wr_valid_i),
   .wr_data_i  (wr_data_i),
   .wr_ready_o (wr_ready_o),
   .rd_valid_o (rd_valid_o),
   .rd_ready_i (rd_ready_i),
   .rd_data_o  (rd_data_o),
   .pins_o     (pins_o),
   .fifo_cnt   (fifo_cnt),
   .stage_busy (stage_busy)
);

// File: tb/sbb_engine_tb.sv
module sbb_engine_tb;
   localparam int W = 8;
   localparam int DEPTH = 4;
   localparam int DIV = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   mode_i = 8'h00;
   logic [W-1:0] dir_i = '1;
   logic         wr_valid_i = 1'b0;
   logic [W-1:0] wr_data_i = '0;
   logic         wr_ready_o;
   logic         rd_valid_o;
   logic [W-1:0] rd_data_o;
   logic         rd_ready_i = 1'b0;
   logic [W-1:0] pins_i = '0;
   logic [W-1:0] pins_o;
   logic [W-1:0] pins_oe_o;

   int     n_cmp = 0;
   int     n_bad = 0;
   longint cyc = 0;
   bit     done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sbb_engine #(.W(W), .DEPTH(DEPTH), .TICK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
      .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ready_i(rd_ready_i),
      .pins_i(pins_i), .pins_o(pins_o), .pins_oe_o(pins_oe_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [W-1:0] b, output longint t);
      @(negedge clk);
      wr_valid_i = 1'b1;
      wr_data_i  = b;
      while (!wr_ready_o) @(negedge clk);
      @(posedge clk);
      #1;
      t = cyc;
      wr_valid_i = 1'b0;
   endtask

   task automatic take(output logic [W-1:0] b);
      @(negedge clk);
      while (!rd_valid_o) @(negedge clk);
      b = rd_data_o;
      rd_ready_i = 1'b1;
      @(posedge clk);
      #1;
      rd_ready_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      longint t0, t1, t2;
      logic [W-1:0] r;
      logic [W-1:0] drv;
      int rdy_seen;

      // reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset pins", pins_o, 8'hFF);
      chk("R1 reset rd_valid", rd_valid_o, 0);
      chk("R2 ready in reset mode", wr_ready_o, 0);
      rst_n = 1'b1;
      rdy_seen = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (wr_ready_o) rdy_seen++;
      end
      chk("R2 no ready with mode 0x00", rdy_seen, 0);
      mode_i = 8'h04;

      // R4 timing of sample and drive
      put(8'h55, t0);
      chk("R4 pins unchanged on accept edge", pins_o, 8'hFF);
      chk("R4 sample pushed on accept edge", rd_valid_o, 1);
      chk("R4 sample value", rd_data_o, 8'hFF);
      @(posedge clk);
      #1;
      chk("R4 pins updated next edge", pins_o, 8'h55);
      put(8'hAA, t0);
      take(r); chk("R6 first read of 55,AA", r, 8'hFF);
      take(r); chk("R6 second read of 55,AA", r, 8'h55);
      @(negedge clk);
      chk("R9 pins after AA", pins_o, 8'hAA);

      // clear through mode 0x00 with a queued sample
      put(8'h3C, t0);
      @(negedge clk);
      mode_i = 8'h00;
      @(posedge clk);
      #1;
      chk("R1 clear pins", pins_o, 8'hFF);
      chk("R1 clear queue", rd_valid_o, 0);
      @(negedge clk);
      mode_i = 8'h04;

      // repeated last byte
      put(8'h55, t0);
      put(8'hAA, t0);
      put(8'hAA, t0);
      take(r); chk("R6 read 1 of 55,AA,AA", r, 8'hFF);
      take(r); chk("R6 read 2 of 55,AA,AA", r, 8'h55);
      take(r); chk("R6 read 3 of 55,AA,AA", r, 8'hAA);

      // tick spacing
      put(8'h01, t0);
      put(8'h02, t1);
      put(8'h03, t2);
      chk("R8 spacing 1", 32'(t1 - t0), DIV);
      chk("R8 spacing 2", 32'(t2 - t1), DIV);
      take(r); chk("R8 lagged read a", r, 8'hAA);
      take(r); chk("R8 lagged read b", r, 8'h01);
      take(r); chk("R8 lagged read c", r, 8'h02);
      drv = 8'h03;

      // full queue back-pressure and order
      put(8'h11, t0);
      put(8'h22, t0);
      put(8'h33, t0);
      put(8'h44, t0);
      rdy_seen = 0;
      wr_valid_i = 1'b1;
      wr_data_i  = 8'hEE;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (wr_ready_o) rdy_seen++;
      end
      wr_valid_i = 1'b0;
      chk("R3 no ready while full", rdy_seen, 0);
      chk("R9 pins hold while stalled", pins_o, 8'h44);
      take(r); chk("R7 order 0", r, drv);
      take(r); chk("R7 order 1", r, 8'h11);
      take(r); chk("R7 order 2", r, 8'h22);
      take(r); chk("R7 order 3", r, 8'h33);
      @(negedge clk);
      chk("R7 empty after drain", rd_valid_o, 0);
      drv = 8'h44;

      // direction mask sweep
      for (int i = 0; i < 64; i++) begin
         logic [W-1:0] dmask, ext, b, expv;
         dmask = 8'((i * 29 + 7) ^ (i << 3));
         ext   = 8'((i * 113) ^ 8'hC3);
         b     = 8'(i * 71 + 5);
         @(negedge clk);
         dir_i  = dmask;
         pins_i = ext;
         expv = (drv & dmask) | (ext & ~dmask);
         put(b, t0);
         take(r);
         chk($sformatf("R5 sample i=%0d", i), r, expv);
         chk($sformatf("R10 oe i=%0d", i), pins_oe_o, dmask);
         chk($sformatf("R4 drive i=%0d", i), pins_o, b);
         drv = b;
      end

      // other mode values gate the engine
      @(negedge clk);
      mode_i = 8'h03;
      wr_valid_i = 1'b1;
      wr_data_i  = 8'h5A;
      rdy_seen = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (wr_ready_o) rdy_seen++;
      end
      wr_valid_i = 1'b0;
      chk("R2 no ready with mode 0x03", rdy_seen, 0);
      chk("R2 pins untouched with mode 0x03", pins_o, drv);
      chk("R2 queue untouched with mode 0x03", rd_valid_o, 0);
      mode_i = 8'h04;

      finish_run();
   end

endmodule